// File: doc/BRIEF.md
# Paired-Instruction Accumulator Core

This block is an execution engine for a small stored-program accumulator machine. Its memory holds 40-bit words, and each word carries two 20-bit instructions. Each instruction is an 8-bit operation code followed by a 12-bit address field. The program counter counts half-words. Its lowest bit picks the instruction inside a word, and the remaining bits index the word. Arithmetic works on a 32-bit signed accumulator (AC) and a 32-bit signed multiplier/quotient register (MQ). Both take their operand from the low 32 bits of the addressed word.

A controller or testbench starts work with a one-cycle request. The request asks for a single step, for up to N steps, or for steps until the first fault. When the request completes, the block raises a one-cycle done pulse and holds a 2-bit status:

- 0: success
- 1: illegal operation code
- 2: address out of range
- 3: division by a non-positive divisor

While the core is idle, a debug port can write memory words and read them back one cycle later. AC, MQ and the PC are visible at all times. Division is done by repeated subtraction, one subtraction per cycle, and the core reports busy for the whole time.

Top module: `acc_core`

## Requirements
- R1: After reset, AC, MQ and PC read 0, busy and done are low, and status reads 0.
- R2: Word index is PC>>1. PC bit 0 = 0 selects the upper half of the word: operation code in bits 39:32, address in bits 31:20. PC bit 0 = 1 selects the lower half: operation code in bits 19:12, address in bits 11:0.
- R3: If the PC is 1024 or more when a step begins, that step executes nothing, ends with status 2, and leaves the PC unchanged.
- R4: The address field is checked first: a field of 1024 or more gives status 2. After that, operation codes 0, 4, 17, 22 to 32, and 34 and above give status 1. In both cases AC, MQ, memory and PC are unchanged.
- R5: The operand M is bits 31:0 of the addressed word, taken as signed. The load and arithmetic codes are:

  | Code | Effect |
  |------|--------|
  | 1 | AC=M |
  | 2 | AC=-M |
  | 3 | AC=\|M\| |
  | 5 | AC+=M |
  | 6 | AC-=M |
  | 7 | AC+=\|M\| |
  | 8 | AC-=\|M\| |
  | 9 | MQ=M |
  | 10 | AC=MQ |

  Each of these advances the PC by 1.
- R6: Code 11 sets MQ to the low 32 bits of MQ*M and clears AC.
- R7: Code 12 subtracts M from AC as long as AC >= M (signed) and counts the subtractions. The remainder ends in AC and the count in MQ; a negative AC gives zero subtractions. If M <= 0, the step ends with status 3 and AC, MQ and PC are unchanged.
- R8: Code 13 sets PC to 2*address. Code 14 sets PC to 2*address+1. Codes 15 and 16 do the same jumps only when AC >= 0; otherwise they advance the PC by 1.
- R9: Code 20 shifts AC left by one bit. Code 21 shifts AC right by one bit and fills with zero.
- R10: Code 33 writes AC into bits 31:0 of the addressed word. Code 18 writes AC[11:0] into bits 31:20. Code 19 writes AC[11:0] into bits 11:0. All other bits of the word keep their values.
- R11: The request kind selects the run mode:

  | Kind | Mode |
  |------|------|
  | 0 | one step |
  | 1 | up to count steps, stopping at the first nonzero status |
  | 2 | steps until a nonzero status |

  A count of 0 finishes with status 0 and executes nothing. Done is high for one cycle, while the core is idle, together with the final status.
- R12: While busy is high, requests and debug writes are ignored. While idle, AC, MQ and PC do not change.
- R13: While idle, dbg_rdata shows the word at dbg_addr one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle run request |
| cmd_kind | input | 2 | 0 step, 1 run count steps, 2 run until fault |
| cmd_count | input | 16 | Step count for kind 1 |
| busy | output | 1 | Core is executing |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Final status of the last request |
| dbg_we | input | 1 | Debug word write (idle only) |
| dbg_addr | input | 10 | Debug word address |
| dbg_wdata | input | 40 | Debug write data |
| dbg_rdata | output | 40 | Debug read data, one cycle latency |
| ac | output | 32 | Accumulator |
| mq | output | 32 | Multiplier/quotient register |
| pc | output | 12 | Half-word program counter |

## Verification
A wrong half-word select or a wrong field slice shows up within the same step: AC or the PC differs when done is raised. The bench therefore compares the registers after every single step of a jump program. A store that patches the wrong bits leaves no trace in the registers. It is only exposed when the stored word is read back through the debug port one cycle later. A broken subtraction loop in the divider shows up as a wrong quotient or remainder, or as a done pulse that never arrives before the time limit. Faults are checked by confirming that the PC and AC keep their values at the done pulse.

// File: rtl/acc_pkg.sv
package acc_pkg;
    localparam int WORD_W  = 40;
    localparam int HALF_W  = 20;
    localparam int OP_W    = 8;
    localparam int FLD_W   = 12;
    localparam int DATA_W  = 32;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_DECODE, S_EXEC, S_DIVIDE
    } fsm_e;

    localparam logic [1:0] ST_OK    = 2'd0;
    localparam logic [1:0] ST_BADOP = 2'd1;
    localparam logic [1:0] ST_RANGE = 2'd2;
    localparam logic [1:0] ST_DIV0  = 2'd3;

    localparam logic [1:0] K_STEP = 2'd0;
    localparam logic [1:0] K_NRUN = 2'd1;
    localparam logic [1:0] K_HALT = 2'd2;

    localparam logic [OP_W-1:0] OP_LD    = 8'd1;
    localparam logic [OP_W-1:0] OP_LDN   = 8'd2;
    localparam logic [OP_W-1:0] OP_LDA   = 8'd3;
    localparam logic [OP_W-1:0] OP_ADD   = 8'd5;
    localparam logic [OP_W-1:0] OP_SUB   = 8'd6;
    localparam logic [OP_W-1:0] OP_ADDA  = 8'd7;
    localparam logic [OP_W-1:0] OP_SUBA  = 8'd8;
    localparam logic [OP_W-1:0] OP_LDMQ  = 8'd9;
    localparam logic [OP_W-1:0] OP_MQAC  = 8'd10;
    localparam logic [OP_W-1:0] OP_MUL   = 8'd11;
    localparam logic [OP_W-1:0] OP_DIV   = 8'd12;
    localparam logic [OP_W-1:0] OP_JL    = 8'd13;
    localparam logic [OP_W-1:0] OP_JR    = 8'd14;
    localparam logic [OP_W-1:0] OP_JPL   = 8'd15;
    localparam logic [OP_W-1:0] OP_JPR   = 8'd16;
    localparam logic [OP_W-1:0] OP_STHI  = 8'd18;
    localparam logic [OP_W-1:0] OP_STLO  = 8'd19;
    localparam logic [OP_W-1:0] OP_SHL   = 8'd20;
    localparam logic [OP_W-1:0] OP_SHR   = 8'd21;
    localparam logic [OP_W-1:0] OP_ST    = 8'd33;

    function automatic logic op_legal(input logic [OP_W-1:0] op);
        logic ok;
        ok = 1'b0;
        if ((op >= OP_LD && op <= OP_LDA) || (op >= OP_ADD && op <= OP_JPR) ||
            (op >= OP_STHI && op <= OP_SHR) || op == OP_ST)
            ok = 1'b1;
        return ok;
    endfunction

    function automatic logic [DATA_W-1:0] mag(input logic [DATA_W-1:0] v);
        return v[DATA_W-1] ? (~v + 1'b1) : v;
    endfunction
endpackage

// File: rtl/acc_ram.sv
module acc_ram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 40
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
        rdata <= cells[addr];
    end
endmodule

// File: rtl/acc_decode.sv
module acc_decode
    import acc_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [WORD_W-1:0] word,
    input  logic              lower,
    output logic [HALF_W-1:0] instr,
    output logic              addr_ok,
    output logic              code_ok
);
    localparam logic [FLD_W-1:0] LIMIT = FLD_W'(1 << ADDR_W);

    logic [OP_W-1:0]  code;
    logic [FLD_W-1:0] fld;

    always_comb begin
        instr   = lower ? word[HALF_W-1:0] : word[WORD_W-1:HALF_W];
        code    = instr[HALF_W-1:FLD_W];
        fld     = instr[FLD_W-1:0];
        addr_ok = fld < LIMIT;
        code_ok = op_legal(code);
    end
endmodule

// File: rtl/acc_exec.sv
module acc_exec
    import acc_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PC_W   = 12
) (
    input  logic [OP_W-1:0]   code,
    input  logic [ADDR_W-1:0] fld,
    input  logic [PC_W-1:0]   pc,
    input  logic [DATA_W-1:0] ac,
    input  logic [DATA_W-1:0] mq,
    input  logic [WORD_W-1:0] mword,
    output logic [DATA_W-1:0] ac_n,
    output logic [DATA_W-1:0] mq_n,
    output logic [PC_W-1:0]   pc_n,
    output logic              wr,
    output logic [WORD_W-1:0] wword,
    output logic              is_div
);
    localparam int PAD = PC_W - ADDR_W - 1;

    logic [DATA_W-1:0] m;
    logic [PC_W-1:0]   tgt_hi;
    logic [PC_W-1:0]   tgt_lo;
    logic              ac_pos;

    always_comb begin
        m      = mword[DATA_W-1:0];
        tgt_hi = {{PAD{1'b0}}, fld, 1'b0};
        tgt_lo = {{PAD{1'b0}}, fld, 1'b1};
        ac_pos = ~ac[DATA_W-1];
        ac_n   = ac;
        mq_n   = mq;
        pc_n   = pc + 1'b1;
        wr     = 1'b0;
        wword  = mword;
        is_div = 1'b0;
        case (code)
            OP_LD:   ac_n = m;
            OP_LDN:  ac_n = ~m + 1'b1;
            OP_LDA:  ac_n = mag(m);
            OP_ADD:  ac_n = ac + m;
            OP_SUB:  ac_n = ac - m;
            OP_ADDA: ac_n = ac + mag(m);
            OP_SUBA: ac_n = ac - mag(m);
            OP_LDMQ: mq_n = m;
            OP_MQAC: ac_n = mq;
            OP_MUL: begin
                mq_n = mq * m;
                ac_n = '0;
            end
            OP_DIV:  is_div = 1'b1;
            OP_JL:   pc_n = tgt_hi;
            OP_JR:   pc_n = tgt_lo;
            OP_JPL:  if (ac_pos) pc_n = tgt_hi;
            OP_JPR:  if (ac_pos) pc_n = tgt_lo;
            OP_SHL:  ac_n = {ac[DATA_W-2:0], 1'b0};
            OP_SHR:  ac_n = {1'b0, ac[DATA_W-1:1]};
            OP_ST: begin
                wr    = 1'b1;
                wword = {mword[WORD_W-1:DATA_W], ac};
            end
            OP_STHI: begin
                wr    = 1'b1;
                wword = {mword[39:32], ac[11:0], mword[19:0]};
            end
            OP_STLO: begin
                wr    = 1'b1;
                wword = {mword[39:12], ac[11:0]};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_kind,
    input  logic [CNT_W-1:0]  cmd_count,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    input  logic              dbg_we,
    input  logic [ADDR_W-1:0] dbg_addr,
    input  logic [WORD_W-1:0] dbg_wdata,
    output logic [WORD_W-1:0] dbg_rdata,
    output logic [DATA_W-1:0] ac,
    output logic [DATA_W-1:0] mq,
    output logic [ADDR_W+1:0] pc
);
    localparam int PC_W = ADDR_W + 2;
    localparam logic [PC_W-1:0] PC_LIMIT = PC_W'(1 << ADDR_W);

    typedef struct packed {
        fsm_e              st;
        logic [PC_W-1:0]   pc;
        logic [DATA_W-1:0] ac;
        logic [DATA_W-1:0] mq;
        logic [DATA_W-1:0] dvs;
        logic [HALF_W-1:0] ir;
        logic              halt_mode;
        logic [CNT_W-1:0]  left;
        logic [1:0]        status;
        logic              done;
    } regs_t;

    regs_t r_q, r_d;

    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [WORD_W-1:0] mem_wdata;
    logic [WORD_W-1:0] mem_rdata;

    logic [HALF_W-1:0] dec_instr;
    logic              dec_addr_ok;
    logic              dec_code_ok;

    logic [DATA_W-1:0] ex_ac, ex_mq;
    logic [PC_W-1:0]   ex_pc;
    logic              ex_wr, ex_div;
    logic [WORD_W-1:0] ex_word;

    acc_ram #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    acc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .word    (mem_rdata),
        .lower   (r_q.pc[0]),
        .instr   (dec_instr),
        .addr_ok (dec_addr_ok),
        .code_ok (dec_code_ok)
    );

    acc_exec #(.ADDR_W(ADDR_W), .PC_W(PC_W)) u_exec (
        .code   (r_q.ir[HALF_W-1:FLD_W]),
        .fld    (r_q.ir[ADDR_W-1:0]),
        .pc     (r_q.pc),
        .ac     (r_q.ac),
        .mq     (r_q.mq),
        .mword  (mem_rdata),
        .ac_n   (ex_ac),
        .mq_n   (ex_mq),
        .pc_n   (ex_pc),
        .wr     (ex_wr),
        .wword  (ex_word),
        .is_div (ex_div)
    );

    // Memory port ownership: debug port when idle, engine otherwise.
    always_comb begin
        mem_we    = 1'b0;
        mem_wdata = ex_word;
        mem_addr  = r_q.ir[ADDR_W-1:0];
        case (r_q.st)
            S_IDLE: begin
                mem_we    = dbg_we;
                mem_addr  = dbg_addr;
                mem_wdata = dbg_wdata;
            end
            S_FETCH:  mem_addr = r_q.pc[ADDR_W:1];
            S_DECODE: mem_addr = dec_instr[ADDR_W-1:0];
            S_EXEC:   mem_we   = ex_wr;
            default: ;
        endcase
    end

    always_comb begin
        logic       fin;
        logic [1:0] fin_code;
        logic       step_ok;
        logic [DATA_W-1:0] m;

        r_d      = r_q;
        r_d.done = 1'b0;
        fin      = 1'b0;
        fin_code = ST_OK;
        step_ok  = 1'b0;
        m        = mem_rdata[DATA_W-1:0];

        case (r_q.st)
            S_IDLE: begin
                if (cmd_valid) begin
                    r_d.halt_mode = (cmd_kind == K_HALT);
                    r_d.left      = (cmd_kind == K_NRUN) ? cmd_count : CNT_W'(1);
                    if (cmd_kind == K_NRUN && cmd_count == '0) begin
                        fin = 1'b1;
                    end else begin
                        r_d.st = S_FETCH;
                    end
                end
            end
            S_FETCH: begin
                if (r_q.pc >= PC_LIMIT) begin
                    fin      = 1'b1;
                    fin_code = ST_RANGE;
                end else begin
                    r_d.st = S_DECODE;
                end
            end
            S_DECODE: begin
                r_d.ir = dec_instr;
                if (!dec_addr_ok) begin
                    fin      = 1'b1;
                    fin_code = ST_RANGE;
                end else if (!dec_code_ok) begin
                    fin      = 1'b1;
                    fin_code = ST_BADOP;
                end else begin
                    r_d.st = S_EXEC;
                end
            end
            S_EXEC: begin
                if (ex_div) begin
                    if (m[DATA_W-1] || m == '0) begin
                        fin      = 1'b1;
                        fin_code = ST_DIV0;
                    end else begin
                        r_d.dvs = m;
                        r_d.mq  = '0;
                        r_d.st  = S_DIVIDE;
                    end
                end else begin
                    r_d.ac  = ex_ac;
                    r_d.mq  = ex_mq;
                    r_d.pc  = ex_pc;
                    step_ok = 1'b1;
                end
            end
            S_DIVIDE: begin
                if ($signed(r_q.ac) >= $signed(r_q.dvs)) begin
                    r_d.ac = r_q.ac - r_q.dvs;
                    r_d.mq = r_q.mq + 1'b1;
                end else begin
                    r_d.pc  = r_q.pc + 1'b1;
                    step_ok = 1'b1;
                end
            end
            default: r_d.st = S_IDLE;
        endcase

        if (step_ok) begin
            if (r_q.halt_mode) begin
                r_d.st = S_FETCH;
            end else if (r_q.left == CNT_W'(1)) begin
                fin = 1'b1;
            end else begin
                r_d.left = r_q.left - 1'b1;
                r_d.st   = S_FETCH;
            end
        end

        if (fin) begin
            r_d.st     = S_IDLE;
            r_d.status = fin_code;
            r_d.done   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != S_IDLE);
    assign done      = r_q.done;
    assign status    = r_q.status;
    assign ac        = r_q.ac;
    assign mq        = r_q.mq;
    assign pc        = r_q.pc;
    assign dbg_rdata = mem_rdata;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
    parameter int PC_W = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic            busy,
    input logic            done,
    input logic [1:0]      status,
    input logic [31:0]     ac,
    input logic [31:0]     mq,
    input logic [PC_W-1:0] pc
);
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R11

    AST_STATUS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (status != $past(status)) |-> done); // R11

    AST_START_ON_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid)); // R12

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(ac) && $stable(mq) && $stable(pc))); // R12

    AST_FAULT_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status != 2'd0) |-> $stable(pc)); // R4
endmodule

bind acc_core acc_core_chk #(.PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .done      (done),
    .status    (status),
    .ac        (ac),
    .mq        (mq),
    .pc        (pc)
);

// File: tb/acc_core_test.sv
module acc_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_kind = 2'd0;
    logic [15:0] cmd_count = 16'd0;
    logic        busy, done;
    logic [1:0]  status;
    logic        dbg_we = 1'b0;
    logic [9:0]  dbg_addr = 10'd0;
    logic [39:0] dbg_wdata = 40'd0;
    logic [39:0] dbg_rdata;
    logic [31:0] ac, mq;
    logic [11:0] pc;

    int errors = 0;
    int checks = 0;
    int pulses = 0;

    always #10 clk = ~clk;

    acc_core uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_count(cmd_count), .busy(busy), .done(done), .status(status),
        .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
        .dbg_rdata(dbg_rdata), .ac(ac), .mq(mq), .pc(pc)
    );

    typedef struct packed {
        logic [7:0]  op;
        logic [31:0] m;
        logic [31:0] acp;
        logic [31:0] mqp;
        logic [31:0] eac;
        logic [31:0] emq;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{8'd1,  -32'sd5, 32'd0,  32'd0,  -32'sd5, 32'd0},
        '{8'd2,  32'd7,   32'd0,  32'd0,  -32'sd7, 32'd0},
        '{8'd3,  -32'sd9, 32'd0,  32'd0,  32'd9,   32'd0},
        '{8'd5,  -32'sd3, 32'd10, 32'd0,  32'd7,   32'd0},
        '{8'd6,  -32'sd3, 32'd10, 32'd0,  32'd13,  32'd0},
        '{8'd7,  -32'sd3, 32'd10, 32'd0,  32'd13,  32'd0},
        '{8'd8,  -32'sd3, 32'd10, 32'd0,  32'd7,   32'd0},
        '{8'd9,  32'd42,  32'd5,  32'd1,  32'd5,   32'd42},
        '{8'd10, 32'd0,   32'd5,  32'd77, 32'd77,  32'd77},
        '{8'd11, -32'sd7, 32'd5,  32'd6,  32'd0,   -32'sd42},
        '{8'd12, 32'd5,   32'd17, 32'd9,  32'd2,   32'd3},
        '{8'd12, 32'd3,   -32'sd4, 32'd9, -32'sd4, 32'd0},
        '{8'd20, 32'd0,   32'h40000001, 32'd0, 32'h80000002, 32'd0},
        '{8'd21, 32'd0,   32'hFFFFFFFE, 32'd0, 32'h7FFFFFFF, 32'd0}
    };

    function automatic logic [39:0] iw(input logic [7:0] lop, input logic [11:0] la,
                                       input logic [7:0] rop, input logic [11:0] ra);
        return {lop, la, rop, ra};
    endfunction

    function automatic logic [39:0] dw(input logic [31:0] v);
        return {8'h00, v};
    endfunction

    task automatic chk(input string req, input logic [39:0] got, input logic [39:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic mem_wr(input logic [9:0] a, input logic [39:0] d);
        @(negedge clk);
        dbg_we = 1'b1; dbg_addr = a; dbg_wdata = d;
        @(negedge clk);
        dbg_we = 1'b0;
    endtask

    task automatic mem_rd(input logic [9:0] a, output logic [39:0] d);
        @(negedge clk);
        dbg_addr = a;
        @(negedge clk);
        d = dbg_rdata;
    endtask

    task automatic run(input logic [1:0] kind, input logic [15:0] n);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = kind; cmd_count = n;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
        chk("R11 done seen", {39'd0, done}, 40'd1);
    endtask

    always @(posedge clk) if (done) pulses++;

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [39:0] rd;
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1 ac", {8'd0, ac}, 40'd0);
        chk("R1 mq", {8'd0, mq}, 40'd0);
        chk("R1 pc", {28'd0, pc}, 40'd0);
        chk("R1 busy/done/status", {36'd0, busy, done, status}, 40'd0);

        // R13 debug write and read back
        mem_wr(10'd100, 40'h12_3456_789A);
        mem_rd(10'd100, rd);
        chk("R13 readback", rd, 40'h12_3456_789A);

        // Table walk: R5 R6 R7 R9
        for (int v = 0; v < NV; v++) begin
            do_reset();
            mem_wr(10'd0, iw(8'd9, 12'd11, 8'd1, 12'd10));
            mem_wr(10'd1, iw(VECS[v].op, 12'd12, 8'd0, 12'd0));
            mem_wr(10'd10, dw(VECS[v].acp));
            mem_wr(10'd11, dw(VECS[v].mqp));
            mem_wr(10'd12, dw(VECS[v].m));
            run(2'd1, 16'd3);
            chk($sformatf("R5/R6/R7/R9 op%0d ac", VECS[v].op), {8'd0, ac}, {8'd0, VECS[v].eac});
            chk($sformatf("R5/R6/R7/R9 op%0d mq", VECS[v].op), {8'd0, mq}, {8'd0, VECS[v].emq});
            chk($sformatf("R5 op%0d status/pc", VECS[v].op), {26'd0, status, pc}, {26'd0, 2'd0, 12'd3});
        end

        // R2 R8 R3: half select and jumps, stepped
        do_reset();
        mem_wr(10'd0, iw(8'd14, 12'd5, 8'd0, 12'd0));
        mem_wr(10'd5, iw(8'd2, 12'd20, 8'd1, 12'd20));
        mem_wr(10'd6, iw(8'd15, 12'd8, 8'd16, 12'd9));
        mem_wr(10'd7, iw(8'd3, 12'd20, 8'd15, 12'd9));
        mem_wr(10'd9, iw(8'd13, 12'd600, 8'd0, 12'd0));
        mem_wr(10'd20, dw(32'hFFFFFFFF));
        run(2'd0, 16'd0);
        chk("R8 jump right pc", {28'd0, pc}, 40'd11);
        run(2'd0, 16'd0);
        chk("R2 lower half executed ac", {8'd0, ac}, {8'd0, 32'hFFFFFFFF});
        chk("R2 pc", {28'd0, pc}, 40'd12);
        run(2'd0, 16'd0);
        chk("R8 jump+ fall through hi", {28'd0, pc}, 40'd13);
        run(2'd0, 16'd0);
        chk("R8 jump+ fall through lo", {28'd0, pc}, 40'd14);
        run(2'd0, 16'd0);
        chk("R5 abs load ac", {8'd0, ac}, 40'd1);
        run(2'd0, 16'd0);
        chk("R8 jump+ taken pc", {28'd0, pc}, 40'd18);
        run(2'd0, 16'd0);
        chk("R8 jump left pc", {28'd0, pc}, 40'd1200);
        run(2'd0, 16'd0);
        chk("R3 pc limit status/pc", {26'd0, status, pc}, {26'd0, 2'd2, 12'd1200});

        // R4 faults
        do_reset();
        mem_wr(10'd0, iw(8'd1, 12'h400, 8'd0, 12'd0));
        run(2'd0, 16'd0);
        chk("R4 address fault status/pc", {26'd0, status, pc}, {26'd0, 2'd2, 12'd0});
        mem_wr(10'd0, iw(8'd0, 12'h400, 8'd0, 12'd0));
        run(2'd0, 16'd0);
        chk("R4 address checked first", {38'd0, status}, 40'd2);
        mem_wr(10'd0, iw(8'd4, 12'd10, 8'd0, 12'd0));
        run(2'd0, 16'd0);
        chk("R4 code 4 status/pc", {26'd0, status, pc}, {26'd0, 2'd1, 12'd0});
        mem_wr(10'd0, iw(8'd40, 12'd10, 8'd0, 12'd0));
        run(2'd0, 16'd0);
        chk("R4 code 40 status", {38'd0, status}, 40'd1);
        chk("R4 ac untouched", {8'd0, ac}, 40'd0);

        // R7 divide fault
        do_reset();
        mem_wr(10'd0, iw(8'd1, 12'd10, 8'd12, 12'd11));
        mem_wr(10'd10, dw(32'd9));
        mem_wr(10'd11, dw(32'd0));
        run(2'd1, 16'd2);
        chk("R7 div0 status/pc", {26'd0, status, pc}, {26'd0, 2'd3, 12'd1});
        chk("R7 div0 ac kept", {8'd0, ac}, 40'd9);

        // R10 stores
        do_reset();
        mem_wr(10'd0, iw(8'd1, 12'd10, 8'd33, 12'd30));
        mem_wr(10'd1, iw(8'd18, 12'd31, 8'd19, 12'd32));
        mem_wr(10'd10, dw(32'h12345678));
        mem_wr(10'd30, 40'hAB_CDEF_0123);
        mem_wr(10'd31, 40'hFF_FFFF_FFFF);
        mem_wr(10'd32, 40'h00_0000_0000);
        run(2'd1, 16'd4);
        chk("R10 status/pc", {26'd0, status, pc}, {26'd0, 2'd0, 12'd4});
        mem_rd(10'd30, rd);
        chk("R10 full store", rd, 40'hAB_1234_5678);
        mem_rd(10'd31, rd);
        chk("R10 upper field store", rd, 40'hFF_678F_FFFF);
        mem_rd(10'd32, rd);
        chk("R10 lower field store", rd, 40'h00_0000_0678);

        // R11 run modes
        do_reset();
        mem_wr(10'd0, iw(8'd1, 12'd10, 8'd5, 12'd10));
        mem_wr(10'd1, iw(8'd0, 12'd0, 8'd0, 12'd0));
        mem_wr(10'd10, dw(32'd3));
        pulses = 0;
        run(2'd1, 16'd5);
        @(negedge clk);
        chk("R11 run-N early stop", {26'd0, status, pc}, {26'd0, 2'd1, 12'd2});
        chk("R11 ac after run", {8'd0, ac}, 40'd6);
        chk("R11 done one cycle", pulses, 40'd1);
        run(2'd1, 16'd0);
        chk("R11 zero count status/pc", {26'd0, status, pc}, {26'd0, 2'd0, 12'd2});
        do_reset();
        run(2'd2, 16'd0);
        chk("R11 run until fault", {26'd0, status, pc}, {26'd0, 2'd1, 12'd2});

        // R12 busy ignores requests and debug writes
        do_reset();
        mem_wr(10'd0, iw(8'd1, 12'd10, 8'd12, 12'd11));
        mem_wr(10'd10, dw(32'd1000));
        mem_wr(10'd11, dw(32'd1));
        mem_wr(10'd50, 40'h11_1111_1111);
        run(2'd0, 16'd0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = 2'd0;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk("R12 busy during divide", {39'd0, busy}, 40'd1);
        dbg_we = 1'b1; dbg_addr = 10'd50; dbg_wdata = 40'h22_2222_2222;
        @(negedge clk);
        dbg_we = 1'b0;
        for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
        chk("R7 long divide quotient", {8'd0, mq}, 40'd1000);
        chk("R7 long divide remainder", {8'd0, ac}, 40'd0);
        repeat (3) @(negedge clk);
        chk("R12 extra request ignored", {27'd0, busy, pc}, {27'd0, 1'b0, 12'd2});
        mem_rd(10'd50, rd);
        chk("R12 debug write ignored", rd, 40'h11_1111_1111);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule